// File: doc/BRIEF.md
# Addressing-Mode Register Step Recorder

This block works out how much a general addressing-mode operand specifier moves its base register. It also keeps a short record of every such move made during the current instruction. It decodes a 3-bit mode, a 3-bit register number and a byte/word flag. From these it drives a signed step and the register it applies to, together with a flag that says the specifier modifies a register at all. A separate output marks modes whose final operand access goes to data space.

The sequencer can override the decoded step with an explicit step and register. It does this, for example, when a subroutine call pushes the link register and moves the stack pointer before the destination specifier is handled.

Each applied step is written into a 16-bit record that holds two register/step pairs. If a step hits the register already held in the most recently filled pair, it is added into that pair. The record is cleared at the start of each instruction. A freeze input holds it, so that a fault handler can read it and undo a partly executed instruction.

Top module: `regstep_log`

## Requirements
- R1: Mode 2 (post-increment) gives a step of +2 when the access is a word or the register is 6 or 7, and +1 otherwise.
- R2: Mode 3 (deferred post-increment) gives +2 in both byte and word accesses.
- R3: Mode 4 (pre-decrement) gives -2 (5-bit code 11110) when the access is a word or the register is 6 or 7, and -1 (11111) otherwise.
- R4: Mode 5 (deferred pre-decrement) gives -2 in both byte and word accesses.
- R5: Modes 0, 1, 6 and 7 drive adjust_o low and a zero step, and an apply in these modes leaves the record unchanged.
- R6: dspace_o is high for modes 3, 4 and 5 and low for all other modes.
- R7: With force_en high, the outputs show force_delta and force_reg with adjust_o high, whatever the mode.
- R8: The first applied step after a clear fills pair 0: register in bits 2:0 and 5-bit two's-complement step in bits 7:3.
- R9: A later step to a different register fills pair 1 in the same layout: register in bits 10:8 and step in bits 15:11.
- R10: A step to the register of the most recently filled pair adds into that pair's step (modulo 32) and takes no new pair.
- R11: Once both pairs are filled, a step to a register other than the one in pair 1 leaves the record unchanged.
- R12: insn_start high at a clock edge clears the record to zero, and this takes priority over apply.
- R13: While freeze is high, the record holds its value through both clear and apply.
- R14: With apply low, the record is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spec_mode | input | 3 | Addressing mode of the specifier |
| spec_reg | input | 3 | Register number of the specifier |
| byte_op | input | 1 | High for a byte access |
| apply | input | 1 | Record the current step at the clock edge |
| force_en | input | 1 | Use the explicit step and register |
| force_delta | input | 5 | Explicit signed step |
| force_reg | input | 3 | Explicit register |
| insn_start | input | 1 | Clear the record |
| freeze | input | 1 | Hold the record |
| delta_o | output | 5 | Signed step, two's complement |
| reg_o | output | 3 | Register the step applies to |
| adjust_o | output | 1 | The specifier modifies a register |
| dspace_o | output | 1 | The final operand access goes to data space |
| log_o | output | 16 | Two-pair step record |

## Verification
The properties assume that freeze, insn_start and apply are only sampled at clock edges, and that force_delta is nonzero whenever force_en is high. A zero forced step would be legal, but the properties do not need to consider it. The stimulus changes inputs only at falling edges and forces only -2 against register 6. Because of this, every property about holding or clearing the record can be judged from the inputs seen at the preceding edge.

// File: rtl/regstep_log.sv
module regstep_log #(
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    spec_mode,
  input  logic [2:0]    spec_reg,
  input  logic          byte_op,
  input  logic          apply,
  input  logic          force_en,
  input  logic [DW-1:0] force_delta,
  input  logic [2:0]    force_reg,
  input  logic          insn_start,
  input  logic          freeze,
  output logic [DW-1:0] delta_o,
  output logic [2:0]    reg_o,
  output logic          adjust_o,
  output logic          dspace_o,
  output logic [2*(DW+3)-1:0] log_o
);
  localparam int SW = DW + 3;

  logic [DW-1:0] dec_delta;
  logic          dec_adj;
  logic          wide;
  logic [1:0]    fill;
  logic [2:0]    r0, r1;
  logic [DW-1:0] d0, d1;

  assign wide = !byte_op || spec_reg[2:1] == 2'b11;

  always_comb begin
    dec_delta = '0;
    dec_adj   = 1'b1;
    case (spec_mode)
      3'd2: dec_delta = wide ? DW'(2) : DW'(1);
      3'd3: dec_delta = DW'(2);
      3'd4: dec_delta = wide ? -DW'(2) : -DW'(1);
      3'd5: dec_delta = -DW'(2);
      default: dec_adj = 1'b0;
    endcase
  end

  assign delta_o  = force_en ? force_delta : dec_delta;
  assign reg_o    = force_en ? force_reg : spec_reg;
  assign adjust_o = force_en | dec_adj;
  assign dspace_o = spec_mode == 3'd3 || spec_mode == 3'd4 || spec_mode == 3'd5;

  assign r0 = log_o[2:0];
  assign d0 = log_o[SW-1:3];
  assign r1 = log_o[SW+2:SW];
  assign d1 = log_o[2*SW-1:SW+3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_o <= '0;
      fill  <= 2'd0;
    end else if (freeze) begin
      log_o <= log_o;
    end else if (insn_start) begin
      log_o <= '0;
      fill  <= 2'd0;
    end else if (apply && adjust_o) begin
      case (fill)
        2'd0: begin
          log_o[SW-1:0] <= {delta_o, reg_o};
          fill <= 2'd1;
        end
        2'd1: begin
          if (reg_o == r0) log_o[SW-1:3] <= d0 + delta_o;
          else begin
            log_o[2*SW-1:SW] <= {delta_o, reg_o};
            fill <= 2'd2;
          end
        end
        default: begin
          if (reg_o == r1) log_o[2*SW-1:SW+3] <= d1 + delta_o;
        end
      endcase
    end
  end
endmodule

module regstep_log_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  spec_mode,
  input logic        force_en,
  input logic        apply,
  input logic        insn_start,
  input logic        freeze,
  input logic [4:0]  delta_o,
  input logic        adjust_o,
  input logic        dspace_o,
  input logic [15:0] log_o
);
  // R5
  no_step_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adjust_o |-> delta_o == 5'd0);
  // R2
  defer_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_mode == 3'd3 && !force_en) |-> delta_o == 5'd2);
  // R4
  defer_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_mode == 3'd5 && !force_en) |-> delta_o == 5'd30);
  // R6
  dspace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_mode == 3'd0 || spec_mode == 3'd1) |-> !dspace_o);
  // R12
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_start && !freeze) |=> log_o == 16'd0);
  // R13
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(log_o));
  // R14
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!apply && !insn_start) |=> $stable(log_o));
endmodule

bind regstep_log regstep_log_chk i_chk (
  .clk(clk), .rst_n(rst_n), .spec_mode(spec_mode), .force_en(force_en),
  .apply(apply), .insn_start(insn_start), .freeze(freeze),
  .delta_o(delta_o), .adjust_o(adjust_o), .dspace_o(dspace_o), .log_o(log_o)
);

// File: tb/test_regstep_log.sv
module test_regstep_log;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  spec_mode = '0, spec_reg = '0, force_reg = '0;
  logic        byte_op = 1'b0, apply = 1'b0, force_en = 1'b0;
  logic        insn_start = 1'b0, freeze = 1'b0;
  logic [4:0]  force_delta = '0;
  logic [4:0]  delta_o;
  logic [2:0]  reg_o;
  logic        adjust_o, dspace_o;
  logic [15:0] log_o;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  regstep_log i_regstep_log (
    .clk(clk), .rst_n(rst_n), .spec_mode(spec_mode), .spec_reg(spec_reg),
    .byte_op(byte_op), .apply(apply), .force_en(force_en),
    .force_delta(force_delta), .force_reg(force_reg), .insn_start(insn_start),
    .freeze(freeze), .delta_o(delta_o), .reg_o(reg_o), .adjust_o(adjust_o),
    .dspace_o(dspace_o), .log_o(log_o)
  );

  always #(PERIOD/2) clk = ~clk;

  // {mode, reg, byte, delta, adjust, dspace}
  localparam logic [13:0] VEC [13] = '{
    {3'd2, 3'd0, 1'b1, 5'd1,  1'b1, 1'b0},
    {3'd2, 3'd0, 1'b0, 5'd2,  1'b1, 1'b0},
    {3'd2, 3'd6, 1'b1, 5'd2,  1'b1, 1'b0},
    {3'd2, 3'd7, 1'b1, 5'd2,  1'b1, 1'b0},
    {3'd3, 3'd1, 1'b1, 5'd2,  1'b1, 1'b1},
    {3'd4, 3'd2, 1'b1, 5'd31, 1'b1, 1'b1},
    {3'd4, 3'd3, 1'b0, 5'd30, 1'b1, 1'b1},
    {3'd4, 3'd6, 1'b1, 5'd30, 1'b1, 1'b1},
    {3'd5, 3'd4, 1'b1, 5'd30, 1'b1, 1'b1},
    {3'd0, 3'd5, 1'b0, 5'd0,  1'b0, 1'b0},
    {3'd1, 3'd5, 1'b1, 5'd0,  1'b0, 1'b0},
    {3'd6, 3'd7, 1'b0, 5'd0,  1'b0, 1'b0},
    {3'd7, 3'd2, 1'b1, 5'd0,  1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %0h, expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic fe, input logic [4:0] fd, input logic [2:0] fr,
                      input logic [2:0] m, input logic [2:0] r, input logic b,
                      input logic ap, input logic st, input logic fz);
    @(negedge clk);
    force_en = fe; force_delta = fd; force_reg = fr;
    spec_mode = m; spec_reg = r; byte_op = b;
    apply = ap; insn_start = st; freeze = fz;
    @(posedge clk);
    #1;
    apply = 1'b0; insn_start = 1'b0; freeze = 1'b0; force_en = 1'b0;
  endtask

  initial begin
    #(PERIOD*2000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    #(PERIOD*2);
    check("R12 reset", log_o, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      @(negedge clk);
      spec_mode = VEC[i][13:11];
      spec_reg  = VEC[i][10:8];
      byte_op   = VEC[i][7];
      #1;
      // R1 R2 R3 R4 R5 R6
      check("R1-5 step", {delta_o, adjust_o}, {VEC[i][6:2], VEC[i][1]});
      if (VEC[i][1]) check("R1 reg", reg_o, spec_reg);
      check("R6 dspace", dspace_o, VEC[i][0]);
    end

    @(negedge clk);
    spec_mode = 3'd3; spec_reg = 3'd1; force_en = 1'b1;
    force_delta = 5'd30; force_reg = 3'd6;
    #1;
    check("R7 override", {delta_o, reg_o, adjust_o}, {5'd30, 3'd6, 1'b1});
    force_en = 1'b0;

    step(0, 0, 0, 3'd0, 3'd0, 0, 0, 1, 0);
    step(0, 0, 0, 3'd1, 3'd4, 0, 1, 0, 0);
    check("R5 no log", log_o, 16'h0000);
    step(0, 0, 0, 3'd4, 3'd6, 0, 1, 0, 0);
    check("R8 first pair", log_o, 16'h00F6);
    step(0, 0, 0, 3'd2, 3'd3, 1, 1, 0, 0);
    check("R9 second pair", log_o, 16'h0BF6);
    step(0, 0, 0, 3'd2, 3'd3, 1, 1, 0, 0);
    check("R10 merge pair1", log_o, 16'h13F6);
    step(0, 0, 0, 3'd2, 3'd1, 0, 1, 0, 0);
    check("R11 full", log_o, 16'h13F6);
    step(0, 0, 0, 3'd4, 3'd5, 0, 0, 0, 0);
    check("R14 no apply", log_o, 16'h13F6);
    step(0, 0, 0, 3'd4, 3'd3, 0, 1, 1, 1);
    check("R13 freeze", log_o, 16'h13F6);
    step(0, 0, 0, 3'd4, 3'd3, 0, 1, 1, 0);
    check("R12 clear over apply", log_o, 16'h0000);
    step(1, 5'd30, 3'd6, 3'd0, 3'd0, 0, 1, 0, 0);
    check("R7 forced log", log_o, 16'h00F6);
    step(0, 0, 0, 3'd2, 3'd6, 0, 1, 0, 0);
    check("R10 merge pair0", log_o, 16'h0006);
    step(0, 0, 0, 3'd3, 3'd7, 1, 1, 0, 0);
    check("R9 after merge", log_o, 16'h1706);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule